// File: doc/BRIEF.md
# Counter-Based Way Replacement Selector

This block holds the replacement state of a set-associative cache and names the way to overwrite on a miss. Every way of every set owns a 2-bit usage counter kept in flip-flops. A freshly used way is loaded with a reload value. Other ways in the set age by conditional decrements, so a low counter means the way has not been touched for a while.

The cache controller presents a set index, an operation code, a way index and a valid strobe. For a miss it reads `victimWay`, which is derived combinationally from the counters of the addressed set. In the same cycle it issues the allocate operation. The counters of that set are updated at the next clock edge. Tags, data and refill sequencing belong to the surrounding cache.

Top module: `usage_victim_sel`

## Requirements
- R1: An active-low asynchronous reset clears every counter to 0, so after reset `victimWay` reads 0 for every set.
- R2: The reload value is USAGE_STATES-1. USAGE_STATES must be 2, 3 or 4, and any other value stops elaboration. No counter ever exceeds the reload value.
- R3: Operation code 2'b01 (hit on `wayIdx`) decrements by one every way of the addressed set whose counter is strictly greater than the hit way's counter, and loads the hit way with the reload value.
- R4: `victimWay` is the way of the addressed set with the smallest counter strictly below the reload value. On a tie the lowest-numbered way wins. If no counter is below the reload value, `victimWay` is 0.
- R5: After any update, at most one way of a set holds the reload value, so with two or more ways the way just loaded is never the next victim.
- R6: Operation code 2'b10 (miss allocate) decrements by one every nonzero counter of the addressed set, and then loads the way shown on `victimWay` in that cycle with the reload value.
- R7: Operation code 2'b11 (invalidate `wayIdx`) clears that way's counter to 0 and leaves the other ways unchanged.
- R8: An update takes effect at the first rising clock edge with `opValid` high and touches only the addressed set. `victimWay` follows `setIdx` without a clock.
- R9: When `opValid` is low, or when the operation code is 2'b00, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Qualifies `opCode` for this cycle |
| opCode | input | 2 | 00 none, 01 hit, 10 miss allocate, 11 invalidate |
| setIdx | input | log2(NUM_SETS) | Addressed set |
| wayIdx | input | log2(NUM_WAYS) | Way for hit or invalidate |
| victimWay | output | log2(NUM_WAYS) | Replacement choice for the addressed set |

## Verification
The embedded properties check the following on every cycle:
- the counters stay bounded by the reload value;
- a set never holds two ways at the reload value;
- a nonzero victim always sits below the reload value;
- hit, allocate and invalidate leave the expected value in the targeted counter;
- an idle cycle leaves all state frozen.

The decrement pattern applied to the other ways, tie-breaking toward the lowest way, and the fact that only the addressed set moves can only be shown by the bench's scenarios. The bench runs a small configuration through directed sequences and a long pseudo-random sweep, comparing `victimWay` of every set against an arithmetic model of the counters.

// File: rtl/usage_victim_pkg.sv
package usage_victim_pkg;

  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_HIT   = 2'b01,
    OP_MISS  = 2'b10,
    OP_INVAL = 2'b11
  } repl_op_e;

  typedef struct packed {
    logic hitUpd;
    logic missUpd;
    logic invalUpd;
  } upd_strobe_t;

endpackage

// File: rtl/usage_victim_ctrl.sv
module usage_victim_ctrl
  import usage_victim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [1:0]  opCode,
  output upd_strobe_t strobes
);

  always_comb begin
    strobes = '0;
    if (opValid) begin
      case (repl_op_e'(opCode))
        OP_HIT:   strobes.hitUpd   = 1'b1;
        OP_MISS:  strobes.missUpd  = 1'b1;
        OP_INVAL: strobes.invalUpd = 1'b1;
        default:  strobes = '0;
      endcase
    end
  end

  // R9: at most one kind of update per cycle
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/usage_victim_pick.sv
module usage_victim_pick
  import usage_victim_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int USAGE_STATES = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_WAYS-1:0][CNT_W-1:0]  rowCnt,
  output logic [WAY_W-1:0]                victimWay
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(USAGE_STATES - 1);

  logic [CNT_W-1:0] bestCnt;

  // Scan upward; strict compare keeps the lowest way on ties
  always_comb begin
    victimWay = '0;
    bestCnt   = RELOAD;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (rowCnt[w] < bestCnt) begin
        victimWay = WAY_W'(w);
        bestCnt   = rowCnt[w];
      end
    end
  end

  // R4: a nonzero choice must be a way below the reload value
  p_victim_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (victimWay != '0) |-> (rowCnt[victimWay] < RELOAD));

endmodule

// File: rtl/usage_victim_dp.sv
module usage_victim_dp
  import usage_victim_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int USAGE_STATES = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  upd_strobe_t       strobes,
  input  logic [SET_W-1:0]  setIdx,
  input  logic [WAY_W-1:0]  wayIdx,
  output logic [WAY_W-1:0]  victimWay
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(USAGE_STATES - 1);

  // R2: static range check of the configuration
  if (USAGE_STATES < 2 || USAGE_STATES > 4) begin : g_bad_states
    $error("usage state count must be 2, 3 or 4");
  end
  if (NUM_SETS < 2 || NUM_SETS > 1024 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
    $error("set count must be a power of two from 2 to 1024");
  end
  if (NUM_WAYS < 2 || NUM_WAYS > 32 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
    $error("way count must be a power of two from 2 to 32");
  end

  logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0] cntQ;
  logic [NUM_WAYS-1:0][CNT_W-1:0]               rowCnt;
  logic [NUM_WAYS-1:0][CNT_W-1:0]               rowNext;
  logic [CNT_W-1:0]                             hitCnt;
  logic                                         rowWrite;

  assign rowCnt   = cntQ[setIdx];
  assign hitCnt   = rowCnt[wayIdx];
  assign rowWrite = strobes.hitUpd | strobes.missUpd | strobes.invalUpd;

  usage_victim_pick #(
    .NUM_WAYS     (NUM_WAYS),
    .USAGE_STATES (USAGE_STATES)
  ) u_pick (
    .clk       (clk),
    .rstN      (rstN),
    .rowCnt    (rowCnt),
    .victimWay (victimWay)
  );

  // Next value of each way of the addressed set
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic isSel;
    logic isVictim;
    assign isSel    = (wayIdx == WAY_W'(w));
    assign isVictim = (victimWay == WAY_W'(w));

    always_comb begin
      rowNext[w] = rowCnt[w];
      if (strobes.hitUpd) begin
        if (isSel)                    rowNext[w] = RELOAD;
        else if (rowCnt[w] > hitCnt)  rowNext[w] = rowCnt[w] - 1'b1;
      end else if (strobes.missUpd) begin
        if (isVictim)                 rowNext[w] = RELOAD;
        else if (rowCnt[w] != '0)     rowNext[w] = rowCnt[w] - 1'b1;
      end else if (strobes.invalUpd) begin
        if (isSel)                    rowNext[w] = '0;
      end
    end

    // R2: counters never exceed the reload value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
      rowCnt[w] <= RELOAD);
  end

  // Counter storage, one enable per set
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cntQ[s] <= '0;
      else if (rowWrite && (setIdx == SET_W'(s)))
        cntQ[s] <= rowNext;
    end
  end

  logic [NUM_WAYS-1:0] atReload;
  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) atReload[w] = (rowCnt[w] == RELOAD);
  end

  // R1: state is clear on leaving reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cntQ == '0));

  // R5: only one way of a set may sit at the reload value
  p_single_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(atReload) <= 1);

  // R3: hit way is loaded with the reload value
  p_hit_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hitUpd |=> (cntQ[$past(setIdx)][$past(wayIdx)] == RELOAD));

  // R6: chosen victim is loaded with the reload value
  p_miss_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.missUpd |=> (cntQ[$past(setIdx)][$past(victimWay)] == RELOAD));

  // R7: invalidated way drops to zero
  p_inval_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.invalUpd |=> (cntQ[$past(setIdx)][$past(wayIdx)] == '0));

  // R9: idle cycles freeze all counters
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(cntQ));

endmodule

// File: rtl/usage_victim_sel.sv
module usage_victim_sel
  import usage_victim_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int USAGE_STATES = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [SET_W-1:0]  setIdx,
  input  logic [WAY_W-1:0]  wayIdx,
  output logic [WAY_W-1:0]  victimWay
);

  upd_strobe_t strobes;

  usage_victim_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  usage_victim_dp #(
    .NUM_SETS     (NUM_SETS),
    .NUM_WAYS     (NUM_WAYS),
    .USAGE_STATES (USAGE_STATES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .setIdx    (setIdx),
    .wayIdx    (wayIdx),
    .victimWay (victimWay)
  );

endmodule

// File: tb/tb_usage_victim_sel.sv
module tb_usage_victim_sel;

  localparam int CLK_PERIOD = 10;
  localparam int T_SETS   = 4;
  localparam int T_WAYS   = 4;
  localparam int T_STATES = 3;
  localparam int T_RELOAD = T_STATES - 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic [1:0] setIdx = '0;
  logic [1:0] wayIdx = '0;
  logic [1:0] victimWay;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mdl [T_SETS][T_WAYS];
  int unsigned rng = 32'h1234_5678;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usage_victim_sel #(
    .NUM_SETS     (T_SETS),
    .NUM_WAYS     (T_WAYS),
    .USAGE_STATES (T_STATES)
  ) dut (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opCode    (opCode),
    .setIdx    (setIdx),
    .wayIdx    (wayIdx),
    .victimWay (victimWay)
  );

  function automatic int mVictim(int s);
    int best = T_RELOAD;
    int v = 0;
    for (int w = 0; w < T_WAYS; w++) begin
      if (mdl[s][w] < best) begin
        best = mdl[s][w];
        v = w;
      end
    end
    return v;
  endfunction

  function automatic int nextRand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return int'(rng & 32'h7fff_ffff);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Model update following the requirements
  task automatic mApply(int op, int s, int w, int vic);
    int row [T_WAYS];
    for (int i = 0; i < T_WAYS; i++) row[i] = mdl[s][i];
    if (op == 1) begin
      for (int i = 0; i < T_WAYS; i++)
        if (i != w && row[i] > row[w]) mdl[s][i] = row[i] - 1;
      mdl[s][w] = T_RELOAD;
    end else if (op == 2) begin
      for (int i = 0; i < T_WAYS; i++)
        if (row[i] != 0) mdl[s][i] = row[i] - 1;
      mdl[s][vic] = T_RELOAD;
    end else if (op == 3) begin
      mdl[s][w] = 0;
    end
  endtask

  // valid: drive opValid; op: code. Checks victim before and after.
  task automatic doOp(bit valid, int op, int s, int w);
    int vic;
    int eff;
    string tag;
    eff = valid ? op : 0;
    @(negedge clk);
    opValid = valid;
    opCode  = 2'(op);
    setIdx  = 2'(s);
    wayIdx  = 2'(w);
    #1;
    vic = mVictim(s);
    check("R4 victim before update", int'(victimWay), vic);
    @(posedge clk);
    mApply(eff, s, w, vic);
    @(negedge clk);
    opValid = 1'b0;
    #1;
    case (eff)
      1: tag = "R3 after hit";
      2: tag = "R6 after miss allocate";
      3: tag = "R7 after invalidate";
      default: tag = "R9 after idle or none";
    endcase
    check(tag, int'(victimWay), mVictim(s));
    if (eff == 1) check("R5 hit way not next victim", int'(victimWay == 2'(w)), 0);
    if (eff == 2) check("R5 filled way not next victim", int'(victimWay == 2'(vic)), 0);
  endtask

  // R8: combinational scan of all sets, no clock edge between reads
  task automatic scanSets(string tag);
    @(negedge clk);
    opValid = 1'b0;
    for (int s = 0; s < T_SETS; s++) begin
      setIdx = 2'(s);
      #1;
      check(tag, int'(victimWay), mVictim(s));
    end
  endtask

  task automatic expectVictim(int s, int exp, string tag);
    @(negedge clk);
    opValid = 1'b0;
    setIdx = 2'(s);
    #1;
    check(tag, int'(victimWay), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < T_SETS; s++)
      for (int w = 0; w < T_WAYS; w++) mdl[s][w] = 0;
    repeat (3) @(posedge clk);
    for (int s = 0; s < T_SETS; s++) expectVictim(s, 0, "R1 victim in reset");
    @(negedge clk);
    rstN = 1'b1;
    for (int s = 0; s < T_SETS; s++) expectVictim(s, 0, "R1 victim after reset");

    // Directed sequence in set 1, reload value 2
    doOp(1'b1, 2, 1, 0); expectVictim(1, 1, "R6 first fill");
    doOp(1'b1, 2, 1, 0); expectVictim(1, 2, "R6 second fill");
    doOp(1'b1, 2, 1, 0); expectVictim(1, 0, "R2 R4 aged way ties lowest");
    doOp(1'b1, 1, 1, 3); expectVictim(1, 0, "R3 hit way 3");
    doOp(1'b1, 1, 1, 0); expectVictim(1, 1, "R3 hit way 0");
    doOp(1'b1, 1, 1, 1); expectVictim(1, 2, "R3 hit way 1");
    doOp(1'b0, 3, 1, 2); expectVictim(1, 2, "R9 invalidate without valid");
    doOp(1'b1, 0, 1, 2); expectVictim(1, 2, "R9 none code");
    doOp(1'b1, 3, 1, 0); expectVictim(1, 0, "R7 invalidated way chosen");
    expectVictim(0, 0, "R8 other set untouched");
    expectVictim(2, 0, "R8 other set untouched");
    expectVictim(3, 0, "R8 other set untouched");

    // Pseudo-random sweep against the model
    for (int n = 0; n < 1500; n++) begin
      int r;
      int sel;
      r = nextRand();
      sel = r % 5;
      case (sel)
        0: doOp(1'b1, 1, (r >> 4) % T_SETS, (r >> 8) % T_WAYS);
        1: doOp(1'b1, 2, (r >> 4) % T_SETS, (r >> 8) % T_WAYS);
        2: doOp(1'b1, 3, (r >> 4) % T_SETS, (r >> 8) % T_WAYS);
        3: doOp(1'b0, (r >> 12) % 4, (r >> 4) % T_SETS, (r >> 8) % T_WAYS);
        default: doOp(1'b1, 0, (r >> 4) % T_SETS, (r >> 8) % T_WAYS);
      endcase
      if (n % 16 == 15) scanSets("R8 all sets match model");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule